// File: doc/BRIEF.md
# Write and Erase Gate Sequencer

This block drives the write side of a flexible disk head. A write request is turned into an internal write gate only while the drive is selected and the head positioner is not stepping. While that gate is open, a stream of write-data pulses steers current alternately into the two halves of the head winding. The tunnel-erase enable follows the gate with two fixed, unequal lags: a short one before erase starts and a longer one before it stops. Both lags are counted in clock cycles derived from a clocks-per-microsecond parameter.

The write-data pulses arrive on a valid/ready stream. `wdata_ready` is high only while the write gate is open. A pulse is taken in a cycle where `wdata_valid` and `wdata_ready` are both high. A pulse offered while `wdata_ready` is low is dropped. It is not held over for later, so a source that must not lose flux transitions should hold them back until it sees ready. `wr_busy` is the write gate itself; the read pulse logic elsewhere is held in reset while it is high.

Top module: `wg_write_erase_seq`

## Requirements
- R1: `wr_busy` goes high one clock after `drv_sel` and `wr_req` are both high with `step_busy` low. It goes low one clock after `wr_req` drops.
- R2: While `step_busy` is high, `wr_busy` is low from the next clock on, whatever the other inputs are.
- R3: Dropping `drv_sel` clears `wr_busy` on the next clock.
- R4: `wdata_ready` equals `wr_busy`. A pulse offered while ready is low changes no output.
- R5: Each pulse accepted with `wdata_valid` and `wdata_ready` high swaps which of `head_a` and `head_b` is high on the next clock, provided the gate is still open.
- R6: After reset, and whenever `wr_busy` is low, `head_a` and `head_b` are both low. Each time the gate opens, `head_a` is the active half.
- R7: `erase_en` is low after reset. It rises exactly ERASE_ON_US*CLK_PER_US clocks after `wr_busy` rises.
- R8: `erase_en` falls exactly ERASE_OFF_US*CLK_PER_US clocks after `wr_busy` falls.
- R9: If the gate closes before the turn-on lag has run out, `erase_en` never rises, and the next opening counts the full turn-on lag again.
- R10: If the gate reopens during the turn-off lag, `erase_en` stays high, and the next closing counts the full turn-off lag again.
- R11: `head_a` and `head_b` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_sel | input | 1 | Drive is selected |
| wr_req | input | 1 | Host asks to write |
| step_busy | input | 1 | Head positioner is stepping; blocks writing |
| wdata_valid | input | 1 | Write-data pulse offered |
| wdata_ready | output | 1 | Write-data pulse can be taken (gate open) |
| head_a | output | 1 | Drive for first winding half |
| head_b | output | 1 | Drive for second winding half |
| erase_en | output | 1 | Erase current enable |
| wr_busy | output | 1 | Write gate active; holds read pulse logic in reset |

## Verification
The assertions check on every cycle the properties that need only a few cycles of history. These are the exclusive head halves, quiet heads while the gate is closed, the swap after each accepted pulse, the gate qualification by select and step-busy, and the rule that erase stays up while the gate is open and changes only on the correct side of the gate. The exact lengths of the two erase lags are checked only by the bench's scenarios, because they span many cycles. The same holds for the aborted turn-on that must never raise erase and the turn-off that must restart in full after a reopening. The bench's reference model also covers those lengths on every clock.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic {HALF_A = 1'b0, HALF_B = 1'b1} head_half_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wg_gate_qual.sv
module wg_gate_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic req_i,
  input  logic step_busy_i,
  output logic gate_o
);
  logic gate_q;

  // Gate opens only with drive selected, a request, and no step in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= sel_i & req_i & ~step_busy_i;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/wg_head_toggle.sv
module wg_head_toggle
  import wg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic take_i,
  output logic head_a_o,
  output logic head_b_o
);
  head_half_t half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      half_q <= HALF_A;
    else if (!gate_i) half_q <= HALF_A;
    else if (take_i) half_q <= (half_q == HALF_A) ? HALF_B : HALF_A;
  end

  assign head_a_o = gate_i & (half_q == HALF_A);
  assign head_b_o = gate_i & (half_q == HALF_B);
endmodule

// File: rtl/wg_erase_timer.sv
module wg_erase_timer
  import wg_pkg::*;
#(
  parameter int ON_CYC  = 50000,
  parameter int OFF_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic erase_o
);
  localparam int CW = $clog2(max_of(ON_CYC, OFF_CYC) + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);

  logic [CW-1:0] on_cnt;
  logic [CW-1:0] off_cnt;
  logic          erase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      off_cnt <= '0;
      erase_q <= 1'b0;
    end else if (gate_i) begin
      off_cnt <= '0;
      if (!erase_q) begin
        if (on_cnt == ON_LAST) begin
          erase_q <= 1'b1;
          on_cnt  <= '0;
        end else begin
          on_cnt <= on_cnt + CW'(1);
        end
      end
    end else begin
      on_cnt <= '0;
      if (erase_q) begin
        if (off_cnt == OFF_LAST) begin
          erase_q <= 1'b0;
          off_cnt <= '0;
        end else begin
          off_cnt <= off_cnt + CW'(1);
        end
      end
    end
  end

  assign erase_o = erase_q;
endmodule

// File: rtl/wg_write_erase_seq.sv
module wg_write_erase_seq #(
  parameter int CLK_PER_US   = 125,
  parameter int ERASE_ON_US  = 400,
  parameter int ERASE_OFF_US = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_sel,
  input  logic wr_req,
  input  logic step_busy,
  input  logic wdata_valid,
  output logic wdata_ready,
  output logic head_a,
  output logic head_b,
  output logic erase_en,
  output logic wr_busy
);
  localparam int ON_CYC  = CLK_PER_US * ERASE_ON_US;
  localparam int OFF_CYC = CLK_PER_US * ERASE_OFF_US;

  logic gate;
  logic take;

  wg_gate_qual u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (drv_sel),
    .req_i       (wr_req),
    .step_busy_i (step_busy),
    .gate_o      (gate)
  );

  assign take = wdata_valid & gate;

  wg_head_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_i   (gate),
    .take_i   (take),
    .head_a_o (head_a),
    .head_b_o (head_b)
  );

  wg_erase_timer #(
    .ON_CYC  (ON_CYC),
    .OFF_CYC (OFF_CYC)
  ) u_erase (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_i  (gate),
    .erase_o (erase_en)
  );

  assign wdata_ready = gate;
  assign wr_busy     = gate;
endmodule

// File: rtl/wg_write_erase_seq_chk.sv
module wg_write_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic drv_sel,
  input logic wr_req,
  input logic step_busy,
  input logic wdata_valid,
  input logic head_a,
  input logic head_b,
  input logic erase_en,
  input logic wr_busy
);
  // R11
  heads_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({head_a, head_b}));

  // R6
  heads_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_busy |-> (!head_a && !head_b));

  // R5
  head_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && $past(wr_busy && wdata_valid)) |-> (head_a != $past(head_a)));

  // R1
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_sel && wr_req && !step_busy) |=> wr_busy);

  // R2
  step_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_busy |=> !wr_busy);

  // R3
  deselect_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_sel |=> !wr_busy);

  // R10
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_en && wr_busy) |=> erase_en);

  // R7
  erase_rise_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_en) |-> $past(wr_busy));

  // R8
  erase_fall_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_en) |-> !$past(wr_busy));
endmodule

bind wg_write_erase_seq wg_write_erase_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drv_sel     (drv_sel),
  .wr_req      (wr_req),
  .step_busy   (step_busy),
  .wdata_valid (wdata_valid),
  .head_a      (head_a),
  .head_b      (head_b),
  .erase_en    (erase_en),
  .wr_busy     (wr_busy)
);

// File: tb/tb_wg_write_erase_seq.sv
module tb_wg_write_erase_seq;
  localparam int CPU = 4;
  localparam int ONU = 10;
  localparam int OFU = 20;
  localparam int ON_N  = CPU * ONU;
  localparam int OFF_N = CPU * OFU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_sel = 1'b0, wr_req = 1'b0, step_busy = 1'b0, wdata_valid = 1'b0;
  logic wdata_ready, head_a, head_b, erase_en, wr_busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wg_write_erase_seq #(.CLK_PER_US(CPU), .ERASE_ON_US(ONU), .ERASE_OFF_US(OFU)) dut (
    .clk(clk), .rst_n(rst_n), .drv_sel(drv_sel), .wr_req(wr_req),
    .step_busy(step_busy), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .head_a(head_a), .head_b(head_b), .erase_en(erase_en), .wr_busy(wr_busy));

  // Behavioural reference: run lengths of gate-open and gate-closed time.
  bit m_gate = 0, m_half = 0, m_erase = 0;
  int run_hi = 0, run_lo = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate = 0; m_half = 0; m_erase = 0; run_hi = 0; run_lo = 0;
    end else begin
      if (m_gate) begin run_hi++; run_lo = 0; end
      else        begin run_lo++; run_hi = 0; end
      if (m_gate) m_erase = m_erase || (run_hi >= ON_N);
      else        m_erase = m_erase && (run_lo < OFF_N);
      if (!m_gate)          m_half = 0;
      else if (wdata_valid) m_half = ~m_half;
      m_gate = drv_sel && wr_req && !step_busy;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(wr_busy == m_gate, "R1 wr_busy vs model", wr_busy, m_gate);
      chk(wdata_ready == m_gate, "R4 wdata_ready vs model", wdata_ready, m_gate);
      chk(head_a == (m_gate && !m_half), "R5 head_a vs model", head_a, m_gate && !m_half);
      chk(head_b == (m_gate && m_half), "R5 head_b vs model", head_b, m_gate && m_half);
      chk(erase_en == m_erase, "R7 R8 erase_en vs model", erase_en, m_erase);
      chk(!(head_a && head_b), "R11 heads exclusive", head_a && head_b, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_until_erase(input bit level, output int n);
    n = 0;
    while (erase_en != level && n < 1000) begin tick(1); n++; end
  endtask

  initial begin
    int n;
    bit seen;
    bit h;
    tick(3);
    chk(!erase_en, "R7 erase low in reset", erase_en, 0);
    chk(!head_a && !head_b, "R6 heads low in reset", head_a | head_b, 0);
    rst_n = 1'b1;

    // R4: pulses offered with gate closed are dropped.
    drv_sel = 1; wdata_valid = 1; tick(4);
    chk(!wdata_ready, "R4 ready low while gate closed", wdata_ready, 0);
    chk(!head_a && !head_b, "R4 ignored pulses leave heads low", head_a | head_b, 0);
    wdata_valid = 0;

    // Open gate; erase turn-on lag while pulses stream every cycle.
    wr_req = 1; tick(1);
    chk(wr_busy, "R1 gate opens after one clock", wr_busy, 1);
    chk(head_a && !head_b, "R6 opening starts on head_a", head_a, 1);
    wdata_valid = 1;
    count_until_erase(1'b1, n);
    chk(n == ON_N, "R7 turn-on lag", n, ON_N);
    wdata_valid = 0; tick(1);
    h = head_a;
    wdata_valid = 1; tick(1); wdata_valid = 0;
    chk(head_a != h, "R5 single pulse swaps halves", head_a, !h);
    tick(2);
    chk(head_a != h, "R5 no swap without pulse", head_a, !h);

    // Close gate; turn-off lag.
    wr_req = 0; tick(1);
    chk(!wr_busy, "R1 gate closes after one clock", wr_busy, 0);
    chk(!head_a && !head_b, "R6 heads low after close", head_a | head_b, 0);
    count_until_erase(1'b0, n);
    chk(n == OFF_N, "R8 turn-off lag", n, OFF_N);

    // R9: short write never raises erase.
    wr_req = 1; tick(ON_N - 8); wr_req = 0;
    seen = 0;
    for (int i = 0; i < ON_N + 10; i++) begin tick(1); if (erase_en) seen = 1; end
    chk(!seen, "R9 aborted turn-on keeps erase low", seen, 0);
    wr_req = 1; tick(1);
    count_until_erase(1'b1, n);
    chk(n == ON_N, "R9 turn-on lag restarts in full", n, ON_N);

    // R10: reopen during the turn-off lag.
    wr_req = 0; tick(OFF_N - 10);
    wr_req = 1; tick(5);
    chk(erase_en, "R10 erase held through reopening", erase_en, 1);
    wr_req = 0; tick(1);
    count_until_erase(1'b0, n);
    chk(n == OFF_N, "R10 turn-off lag restarts in full", n, OFF_N);

    // R2: step in progress blocks the gate.
    wr_req = 1; tick(2);
    wdata_valid = 1; tick(1); wdata_valid = 0;
    step_busy = 1; tick(1);
    chk(!wr_busy, "R2 step_busy drops gate", wr_busy, 0);
    tick(5);
    chk(!wr_busy && !head_a && !head_b, "R2 gate stays closed during step", wr_busy, 0);
    step_busy = 0; tick(1);
    chk(wr_busy && head_a, "R6 reopen after step on head_a", head_a, 1);

    // R3: deselection.
    drv_sel = 0; tick(1);
    chk(!wr_busy, "R3 deselect drops gate", wr_busy, 0);
    tick(OFF_N + 5);
    chk(!erase_en, "R8 erase off after deselect", erase_en, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule